// File: doc/BRIEF.md
# Double-Buffered Sample Capture DMA

This block takes 16-bit samples from an ADC sequencer and writes each one to memory through a single-beat write port. A request stays up until memory acknowledges it. Software programs two destination base addresses and a per-buffer sample count. Capture fills the first buffer and then, with buffer chaining on, moves straight to the second buffer and back again without stopping. Whenever a buffer fills, an end-of-buffer status flag is set. That flag drives an interrupt line through a mask bit.

Software reaches the block through a simple 16-bit register write port. It starts capture by loading the addresses and count, setting the control bits, and issuing a restart sequence that points the engine at the start of the first buffer. A sample that arrives while the previous write is still waiting for its acknowledge is dropped, and a sticky overrun flag records the loss.

Top module: `pcd_top`

## Requirements
- R1: Each destination address is written in two 16-bit halves: low half at offset 0 (first buffer) or 2 (second buffer), then high half at offset 1 or 3. The low half is staged and has no effect until the high-half write commits both halves.
- R2: Offset 4 sets the buffer length in samples. With increment on (offset 6 bit 0 = 1), sample k of a buffer is written to base + 2*k.
- R3: With chaining on (offset 5 bit 0 = 1), the sample after the last one of a buffer goes to the other buffer's base, and the count restarts at zero.
- R4: With chaining off, the engine stops after the last sample of a buffer and ignores further samples until the next restart.
- R5: Filling a buffer sets eop_o. Writing 1 to offset 7 bit 0 clears it. If a set and a clear land in the same cycle, the set wins.
- R6: irq_o is high only while eop_o is high and the mask bit (offset 8 bit 0) is 1.
- R7: With increment off, every sample goes to the current buffer's base address.
- R8: Writing 0 and then 1 to offset 10 bit 0 restarts the engine at the first buffer's base with a zero count.
- R9: With the channel enable (offset 9 bit 0) at 0, no memory write is issued.
- R10: A sample that arrives while a write is still awaiting acknowledge is dropped without advancing the address, and it sets overrun_o. overrun_o stays set until rst_ni.
- R11: mem_req_o and the address and data it carries stay unchanged until mem_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 16 | Register write data |
| smp_valid_i | input | 1 | Sample valid from the ADC sequencer |
| smp_data_i | input | 16 | Sample value |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Byte address of the write |
| mem_data_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| eop_o | output | 1 | End-of-buffer status |
| irq_o | output | 1 | Masked interrupt |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
Four properties are checked on every cycle. A pending request must hold steady until it is acknowledged. The overrun flag must never drop. The interrupt must never be high without the status flag. The status flag may only rise together with an issued write. Address sequencing, buffer swapping across several lengths, staged address halves, the restart sequence, stopping without chaining, and sample dropping can only be shown by the bench scenarios, which compare every issued address against arithmetic built from the programmed bases.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned REG_AW = 4;
  typedef enum logic [REG_AW-1:0] {
    OFF_A_LO  = 4'd0,
    OFF_A_HI  = 4'd1,
    OFF_B_LO  = 4'd2,
    OFF_B_HI  = 4'd3,
    OFF_LEN   = 4'd4,
    OFF_CHAIN = 4'd5,
    OFF_INCR  = 4'd6,
    OFF_STAT  = 4'd7,
    OFF_MASK  = 4'd8,
    OFF_EN    = 4'd9,
    OFF_RST   = 4'd10
  } reg_off_e;
endpackage

// File: rtl/pcd_regs.sv
module pcd_regs import pcd_pkg::*; #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16,
  localparam int unsigned HW = AW / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              eop_set_i,
  output logic [AW-1:0]     dst_a_o,
  output logic [AW-1:0]     dst_b_o,
  output logic [LW-1:0]     len_o,
  output logic              chain_o,
  output logic              incr_o,
  output logic              mask_o,
  output logic              en_o,
  output logic              eop_o,
  output logic              start_o
);
  logic [HW-1:0] a_lo_q, b_lo_q;
  logic          rst_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_lo_q    <= '0;
      b_lo_q    <= '0;
      dst_a_o   <= '0;
      dst_b_o   <= '0;
      len_o     <= LW'(1);
      chain_o   <= 1'b0;
      incr_o    <= 1'b0;
      mask_o    <= 1'b0;
      en_o      <= 1'b0;
      rst_bit_q <= 1'b0;
    end else if (we_i) begin
      unique case (reg_off_e'(addr_i))
        OFF_A_LO:  a_lo_q    <= wdata_i[HW-1:0];
        OFF_A_HI:  dst_a_o   <= {wdata_i[HW-1:0], a_lo_q};
        OFF_B_LO:  b_lo_q    <= wdata_i[HW-1:0];
        OFF_B_HI:  dst_b_o   <= {wdata_i[HW-1:0], b_lo_q};
        OFF_LEN:   len_o     <= wdata_i[LW-1:0];
        OFF_CHAIN: chain_o   <= wdata_i[0];
        OFF_INCR:  incr_o    <= wdata_i[0];
        OFF_MASK:  mask_o    <= wdata_i[0];
        OFF_EN:    en_o      <= wdata_i[0];
        OFF_RST:   rst_bit_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // restart on a 0 -> 1 transition of the reset bit
  assign start_o = we_i && (addr_i == OFF_RST) && wdata_i[0] && !rst_bit_q;

  wire clr_eop = we_i && (addr_i == OFF_STAT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        eop_o <= 1'b0;
    else if (eop_set_i) eop_o <= 1'b1;
    else if (clr_eop)   eop_o <= 1'b0;
  end
endmodule

// File: rtl/pcd_addr_gen.sv
module pcd_addr_gen #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16,
  parameter int unsigned BYTES_PER_SMP = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  input  logic [AW-1:0] dst_a_i,
  input  logic [AW-1:0] dst_b_i,
  input  logic [LW-1:0] len_i,
  input  logic          chain_i,
  input  logic          incr_i,
  output logic [AW-1:0] addr_o,
  output logic          halted_o,
  output logic          eop_o
);
  logic [LW-1:0] cnt_q;
  logic          buf_q;

  wire last = (cnt_q == len_i - LW'(1));
  assign eop_o = step_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      buf_q    <= 1'b0;
      addr_o   <= '0;
      halted_o <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      buf_q    <= 1'b0;
      addr_o   <= dst_a_i;
      halted_o <= 1'b0;
    end else if (step_i) begin
      if (last) begin
        cnt_q <= '0;
        if (chain_i) begin
          buf_q  <= ~buf_q;
          addr_o <= buf_q ? dst_a_i : dst_b_i;
        end else begin
          halted_o <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + LW'(1);
        if (incr_i) addr_o <= addr_o + AW'(BYTES_PER_SMP);
      end
    end
  end
endmodule

// File: rtl/pcd_mem_port.sv
module pcd_mem_port #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          ack_i,
  output logic          busy_o,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  assign busy_o = req_o && !ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else if (issue_i) begin
      req_o  <= 1'b1;
      addr_o <= addr_i;
      data_o <= data_i;
    end else if (ack_i) begin
      req_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/pcd_top.sv
module pcd_top import pcd_pkg::*; #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  input  logic              smp_valid_i,
  input  logic [DW-1:0]     smp_data_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_data_o,
  input  logic              mem_ack_i,
  output logic              eop_o,
  output logic              irq_o,
  output logic              overrun_o
);
  localparam int unsigned SMP_BYTES = DW / 8;

  logic [AW-1:0] dst_a, dst_b, cur_addr;
  logic [LW-1:0] len;
  logic chain, incr, mask, en, start, halted, busy, eop_set;

  pcd_regs #(.AW(AW), .LW(LW)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .eop_set_i(eop_set),
    .dst_a_o(dst_a), .dst_b_o(dst_b), .len_o(len),
    .chain_o(chain), .incr_o(incr), .mask_o(mask), .en_o(en),
    .eop_o(eop_o), .start_o(start)
  );

  wire take  = smp_valid_i && en && !halted;
  wire step  = take && !busy;
  wire drop  = take && busy;

  pcd_addr_gen #(.AW(AW), .LW(LW), .BYTES_PER_SMP(SMP_BYTES)) i_addr_gen (
    .clk_i, .rst_ni,
    .start_i(start), .step_i(step),
    .dst_a_i(dst_a), .dst_b_i(dst_b), .len_i(len),
    .chain_i(chain), .incr_i(incr),
    .addr_o(cur_addr), .halted_o(halted), .eop_o(eop_set)
  );

  pcd_mem_port #(.AW(AW), .DW(DW)) i_mem_port (
    .clk_i, .rst_ni,
    .issue_i(step), .addr_i(cur_addr), .data_i(smp_data_i),
    .ack_i(mem_ack_i), .busy_o(busy),
    .req_o(mem_req_o), .addr_o(mem_addr_o), .data_o(mem_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   overrun_o <= 1'b0;
    else if (drop) overrun_o <= 1'b1;
  end

  assign irq_o = eop_o && mask;
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_data_o,
  input logic          mem_ack_i,
  input logic          eop_o,
  input logic          irq_o,
  input logic          overrun_o
);
  a_r11_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)));

  a_r10_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  a_r6_irq_needs_eop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> eop_o);

  a_r5_eop_with_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eop_o) |-> mem_req_o);
endmodule

bind pcd_top pcd_checker #(.AW(AW), .DW(DW)) i_pcd_checker (
  .clk_i, .rst_ni, .mem_req_o, .mem_addr_o, .mem_data_o,
  .mem_ack_i, .eop_o, .irq_o, .overrun_o
);

// File: tb/test_pcd_top.sv
module test_pcd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  waddr = '0;
  logic [15:0] wdata = '0;
  logic        sv = 1'b0;
  logic [15:0] sd = '0;
  logic        ack = 1'b0;
  logic        req, eop, irq, ovr;
  logic [31:0] maddr;
  logic [15:0] mdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [31:0] BASE_A = 32'h0000_1000;
  localparam logic [31:0] BASE_B = 32'h0002_2000;

  always #2 clk = ~clk;

  pcd_top i_pcd_top (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(waddr),
    .reg_wdata_i(wdata), .smp_valid_i(sv), .smp_data_i(sd),
    .mem_req_o(req), .mem_addr_o(maddr), .mem_data_o(mdata),
    .mem_ack_i(ack), .eop_o(eop), .irq_o(irq), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic restart();
    wr(4'd10, 16'd0); wr(4'd10, 16'd1);
  endtask

  task automatic send(input logic [15:0] d);
    @(negedge clk); sv = 1'b1; sd = d;
    @(negedge clk); sv = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req && !eop && !irq && !ovr, "R11 reset state", {req, eop, irq, ovr}, 0);
    rst_n = 1'b1;
    wr(4'd0, BASE_A[15:0]); wr(4'd1, BASE_A[31:16]);
    wr(4'd2, BASE_B[15:0]); wr(4'd3, BASE_B[31:16]);
    wr(4'd5, 1); wr(4'd6, 1); wr(4'd8, 1); wr(4'd9, 1);

    // R2/R3/R5/R6 sweep over lengths
    for (int len = 1; len <= 4; len++) begin
      wr(4'd4, 16'(len));
      restart();
      wr(4'd7, 1);
      for (int k = 0; k < 3 * len + 1; k++) begin
        logic [31:0] exp_a;
        exp_a = (((k / len) % 2) ? BASE_B : BASE_A) + 32'(2 * (k % len));
        send(16'(k + 16 * len));
        chk(req, "R2 request issued", {31'd0, req}, 1);
        chk(maddr == exp_a, "R3 address", maddr, exp_a);
        chk(mdata == 16'(k + 16 * len), "R2 data", {16'd0, mdata}, k + 16 * len);
        do_ack();
        chk(!req, "R11 request drops after ack", {31'd0, req}, 0);
        if ((k % len) == len - 1) begin
          chk(eop && irq, "R5 eop on buffer end", {30'd0, eop, irq}, 3);
          wr(4'd7, 1);
          chk(!eop && !irq, "R5 w1c clear", {30'd0, eop, irq}, 0);
        end else begin
          chk(!eop, "R5 no eop mid buffer", {31'd0, eop}, 0);
        end
      end
    end

    // R11: hold without ack
    wr(4'd4, 4); restart();
    send(16'h1111);
    repeat (3) @(negedge clk);
    chk(req && maddr == BASE_A && mdata == 16'h1111, "R11 held until ack", maddr, BASE_A);
    do_ack();

    // R7: increment off
    wr(4'd6, 0); restart();
    for (int k = 0; k < 3; k++) begin
      send(16'(k));
      chk(maddr == BASE_A, "R7 fixed address", maddr, BASE_A);
      do_ack();
    end
    wr(4'd6, 1);

    // R4/R6: chaining off, mask off
    wr(4'd5, 0); wr(4'd8, 0); wr(4'd4, 2); restart(); wr(4'd7, 1);
    send(1); do_ack(); send(2); do_ack();
    chk(eop && !irq, "R6 masked eop", {30'd0, eop, irq}, 2);
    send(3);
    chk(!req, "R4 stopped after buffer", {31'd0, req}, 0);
    restart(); send(4);
    chk(req && maddr == BASE_A, "R8 restart to first buffer", maddr, BASE_A);
    do_ack();
    wr(4'd5, 1); wr(4'd8, 1); wr(4'd7, 1);

    // R9: disabled
    wr(4'd9, 0); send(5);
    chk(!req, "R9 disabled no write", {31'd0, req}, 0);
    wr(4'd9, 1);

    // R1: staged low half
    wr(4'd0, 16'h3330); restart(); send(6);
    chk(maddr == BASE_A, "R1 low half staged", maddr, BASE_A);
    do_ack();
    wr(4'd1, 16'h0000); restart(); send(7);
    chk(maddr == 32'h0000_3330, "R1 committed address", maddr, 32'h0000_3330);
    do_ack();

    // R10: overrun
    restart();
    chk(!ovr, "R10 no overrun yet", {31'd0, ovr}, 0);
    send(16'hAAAA); send(16'hBBBB);
    chk(ovr, "R10 overrun set", {31'd0, ovr}, 1);
    chk(mdata == 16'hAAAA && maddr == 32'h0000_3330, "R10 first sample kept", {16'd0, mdata}, 32'hAAAA);
    do_ack();
    send(16'hCCCC);
    chk(maddr == 32'h0000_3332, "R10 dropped sample did not advance", maddr, 32'h0000_3332);
    do_ack();
    chk(ovr, "R10 overrun sticky", {31'd0, ovr}, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual running expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule